// File: doc/BRIEF.md
# Bridge Reset and Initialization Controller

This block sequences reset and bring-up for the two halves of a bridge between a host bus and a local bus. It combines the host reset input, the local reset input and a software reset bit owned by the host. From these it drives one local reset output and separate reset enables for four register groups: host configuration, shared runtime, local configuration and local DMA. A host reset clears everything. A local reset or the software reset clears only the two local groups.

The block holds a small init control register with three bits. The init-done bit is set by the local processor. The software-reset bit is written by the host. The reload bit asks the serial EEPROM engine for a configuration reload and stays high until that engine pulses its done handshake. The block also holds the three enable bits of the host command register. Until init is done, every host cycle is answered with retry, unless the wait strap is low. While a local-side reset is in force, local register accesses are shut out.

Top module: `brg_rst_init`

## Requirements
- R1: `localRstOutN` is low whenever `hostRstN` is low, `localRstInN` is low, or the software-reset bit (bit 30 of the init control register at offset 0xEC) is 1.
- R2: With `hostRstN` low, all four group reset enables are high, the init control register reads 0 and the command enables read 0.
- R3: Each reset input passes through a two-stage synchronizer. Assertion takes effect at once. Release takes effect on the second rising clock edge after the input goes high.
- R4: With `localRstInN` low, `rstLocalCfg` and `rstLocalDma` are high, `rstHostCfg` and `rstRuntime` stay low, and init-done clears. The software-reset bit, the reload bit and the command enables keep their values.
- R5: While the software-reset bit is 1, the local group enables are high and the host group enables are low. A host write of 0 to bit 30 at 0xEC releases it.
- R6: While any local-side reset is in force, `locAccessEn` is low, local writes have no effect and `locRdData` reads 0.
- R7: The reload bit (bit 29 at 0xEC) is set by writing a 1 from either side, drives `eeReloadReq`, and clears on an `eeLoadDone` pulse. A setting write in the same cycle as `eeLoadDone` wins.
- R8: `hostRetry` is high exactly when `waitStrap` is 1 and init-done is 0. Host writes are ignored while `hostRetry` is high.
- R9: Init-done (bit 31 at 0xEC) is set by a local write of 1 to that bit. Local writes of 0 and all host writes leave it unchanged.
- R10: A read at 0xEC returns init-done, software-reset and reload in bits 31, 30 and 29, with zero elsewhere. A read at 0x04 returns the command enables in bits 2:0. Any other offset reads 0.
- R11: The command enables (master, memory space, I/O space) at offset 0x04, bits 2:0, are written by the host and are cleared only by a host reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| hostRstN | input | 1 | Host bus reset, active low, asynchronous |
| localRstInN | input | 1 | Local reset input, active low, asynchronous |
| waitStrap | input | 1 | When high, host cycles wait for init-done |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | ADDR_W | Host register offset |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data |
| locWrEn | input | 1 | Local register write strobe |
| locAddr | input | ADDR_W | Local register offset |
| locWrData | input | DATA_W | Local write data |
| locRdData | output | DATA_W | Local read data |
| eeLoadDone | input | 1 | One-cycle pulse when the EEPROM load finishes |
| eeReloadReq | output | 1 | EEPROM reload request |
| localRstOutN | output | 1 | Local reset output, active low |
| rstHostCfg | output | 1 | Reset enable, host configuration group |
| rstRuntime | output | 1 | Reset enable, shared runtime group |
| rstLocalCfg | output | 1 | Reset enable, local configuration group |
| rstLocalDma | output | 1 | Reset enable, local DMA group |
| locAccessEn | output | 1 | Local-side register access allowed |
| hostRetry | output | 1 | Host cycles must be retried |
| cmdEnables | output | 3 | Master, memory space and I/O space enables |

## Verification
The bench builds the block with its defaults: 32-bit data, 8-bit offsets, a two-stage synchronizer, the control register at 0xEC and the command register at 0x04. With these values the control bits sit in the top three data bits. That lets all-ones host writes show that the reserved bits and the command bits stay separate. A depth of two also makes the release edge of the synchronizer exactly countable. A vector table runs the write, clear and reload sequences. Directed steps then cover each reset source, the strap override and the case where a reload write and the done pulse land in the same cycle.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef struct packed {
    logic icHostWr;
    logic icLocWr;
    logic cmdHostWr;
    logic loadDone;
  } regStrobe_t;
endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic srstN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srstN = chain[STAGES-1];
endmodule

// File: rtl/brg_init_ctl.sv
module brg_init_ctl
  import brg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IC_OFFSET  = 8'hEC,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h04
) (
  input  logic              hostRst,
  input  logic              locRst,
  input  logic              swReset,
  input  logic              initDone,
  input  logic              waitStrap,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              locWrEn,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              eeLoadDone,
  output regStrobe_t        strb,
  output logic              hostRetry,
  output logic              locAccessEn,
  output logic              localRstOutN,
  output logic              rstHostCfg,
  output logic              rstRuntime,
  output logic              rstLocalCfg,
  output logic              rstLocalDma
);
  logic localSideRst;
  logic hostOk;

  always_comb begin
    localSideRst = hostRst | locRst | swReset;
    hostRetry    = waitStrap & ~initDone;
    hostOk       = ~hostRetry & ~hostRst;
    locAccessEn  = ~localSideRst;
    localRstOutN = ~localSideRst;
    rstHostCfg   = hostRst;
    rstRuntime   = hostRst;
    rstLocalCfg  = localSideRst;
    rstLocalDma  = localSideRst;

    strb.icHostWr  = hostOk & hostWrEn & (hostAddr == IC_OFFSET);
    strb.cmdHostWr = hostOk & hostWrEn & (hostAddr == CMD_OFFSET);
    strb.icLocWr   = locAccessEn & locWrEn & (locAddr == IC_OFFSET);
    strb.loadDone  = eeLoadDone;
  end
endmodule

// File: rtl/brg_init_regs.sv
module brg_init_regs
  import brg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 3,
  parameter logic [ADDR_W-1:0] IC_OFFSET  = 8'hEC,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h04
) (
  input  logic              clk,
  input  logic              hostRst,
  input  logic              locRst,
  input  regStrobe_t        strb,
  input  logic              locAccessEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWrData,
  output logic              initDone,
  output logic              swReset,
  output logic              reloadBit,
  output logic [CMD_W-1:0]  cmdEnables,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] locRdData
);
  localparam int DONE_BIT = DATA_W - 1;
  localparam int SWR_BIT  = DATA_W - 2;
  localparam int RLD_BIT  = DATA_W - 3;

  logic reloadSet;
  logic [DATA_W-1:0] icWord;
  logic [DATA_W-1:0] cmdWord;
  logic unusedData;

  assign unusedData = ^{hostWrData, locWrData};
  assign reloadSet = (strb.icHostWr & hostWrData[RLD_BIT]) |
                     (strb.icLocWr  & locWrData[RLD_BIT]);

  always_ff @(posedge clk or posedge hostRst) begin
    if (hostRst) begin
      initDone <= 1'b0;
    end else if (locRst) begin
      initDone <= 1'b0;
    end else if (strb.icLocWr && locWrData[DONE_BIT]) begin
      initDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge hostRst) begin
    if (hostRst) begin
      swReset    <= 1'b0;
      reloadBit  <= 1'b0;
      cmdEnables <= '0;
    end else begin
      if (strb.icHostWr)  swReset    <= hostWrData[SWR_BIT];
      if (strb.cmdHostWr) cmdEnables <= hostWrData[CMD_W-1:0];
      if (reloadSet)          reloadBit <= 1'b1;
      else if (strb.loadDone) reloadBit <= 1'b0;
    end
  end

  always_comb begin
    icWord           = '0;
    icWord[DONE_BIT] = initDone;
    icWord[SWR_BIT]  = swReset;
    icWord[RLD_BIT]  = reloadBit;
    cmdWord              = '0;
    cmdWord[CMD_W-1:0]   = cmdEnables;

    if (hostAddr == IC_OFFSET)       hostRdData = icWord;
    else if (hostAddr == CMD_OFFSET) hostRdData = cmdWord;
    else                             hostRdData = '0;

    if (locAccessEn && locAddr == IC_OFFSET) locRdData = icWord;
    else                                     locRdData = '0;
  end
endmodule

// File: rtl/brg_rst_init.sv
module brg_rst_init
  import brg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IC_OFFSET  = 8'hEC,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 8'h04
) (
  input  logic              clk,
  input  logic              hostRstN,
  input  logic              localRstInN,
  input  logic              waitStrap,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              locWrEn,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [DATA_W-1:0] locWrData,
  output logic [DATA_W-1:0] locRdData,
  input  logic              eeLoadDone,
  output logic              eeReloadReq,
  output logic              localRstOutN,
  output logic              rstHostCfg,
  output logic              rstRuntime,
  output logic              rstLocalCfg,
  output logic              rstLocalDma,
  output logic              locAccessEn,
  output logic              hostRetry,
  output logic [2:0]        cmdEnables
);
  localparam int NUM_SRC = 2;
  localparam int CMD_W   = 3;

  logic [NUM_SRC-1:0] asyncRstN;
  logic [NUM_SRC-1:0] syncRstN;
  logic hostRst, locRst;
  logic initDone, swReset, reloadBit;
  regStrobe_t strb;

  // source 0: host reset; source 1: local reset, also forced by host reset
  assign asyncRstN[0] = hostRstN;
  assign asyncRstN[1] = hostRstN & localRstInN;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    brg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .arstN(asyncRstN[g]),
      .srstN(syncRstN[g])
    );
  end

  assign hostRst     = ~syncRstN[0];
  assign locRst      = ~syncRstN[1];
  assign eeReloadReq = reloadBit;

  brg_init_ctl #(
    .ADDR_W(ADDR_W), .IC_OFFSET(IC_OFFSET), .CMD_OFFSET(CMD_OFFSET)
  ) u_ctl (
    .hostRst     (hostRst),
    .locRst      (locRst),
    .swReset     (swReset),
    .initDone    (initDone),
    .waitStrap   (waitStrap),
    .hostWrEn    (hostWrEn),
    .hostAddr    (hostAddr),
    .locWrEn     (locWrEn),
    .locAddr     (locAddr),
    .eeLoadDone  (eeLoadDone),
    .strb        (strb),
    .hostRetry   (hostRetry),
    .locAccessEn (locAccessEn),
    .localRstOutN(localRstOutN),
    .rstHostCfg  (rstHostCfg),
    .rstRuntime  (rstRuntime),
    .rstLocalCfg (rstLocalCfg),
    .rstLocalDma (rstLocalDma)
  );

  brg_init_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W),
    .IC_OFFSET(IC_OFFSET), .CMD_OFFSET(CMD_OFFSET)
  ) u_regs (
    .clk        (clk),
    .hostRst    (hostRst),
    .locRst     (locRst),
    .strb       (strb),
    .locAccessEn(locAccessEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .locAddr    (locAddr),
    .locWrData  (locWrData),
    .initDone   (initDone),
    .swReset    (swReset),
    .reloadBit  (reloadBit),
    .cmdEnables (cmdEnables),
    .hostRdData (hostRdData),
    .locRdData  (locRdData)
  );
endmodule

// File: rtl/brg_rst_init_chk.sv
module brg_rst_init_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              hostRstN,
  input logic              localRstInN,
  input logic              waitStrap,
  input logic              eeLoadDone,
  input logic              eeReloadReq,
  input logic              localRstOutN,
  input logic              rstHostCfg,
  input logic              rstLocalCfg,
  input logic              rstLocalDma,
  input logic              locAccessEn,
  input logic              hostRetry,
  input logic [DATA_W-1:0] locRdData
);
  // R1
  lrst_follow_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    !localRstInN |-> !localRstOutN);

  // R4
  grp_pair_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    rstLocalCfg == rstLocalDma);

  // R5
  host_nest_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    rstHostCfg |-> rstLocalCfg);

  // R6
  loc_mute_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    !locAccessEn |-> locRdData == '0);

  // R8
  strap_free_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    !waitStrap |-> !hostRetry);

  // R7
  rld_drop_chk: assert property (@(posedge clk) disable iff (!hostRstN)
    $fell(eeReloadReq) |-> $past(eeLoadDone));
endmodule

bind brg_rst_init brg_rst_init_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .hostRstN    (hostRstN),
  .localRstInN (localRstInN),
  .waitStrap   (waitStrap),
  .eeLoadDone  (eeLoadDone),
  .eeReloadReq (eeReloadReq),
  .localRstOutN(localRstOutN),
  .rstHostCfg  (rstHostCfg),
  .rstLocalCfg (rstLocalCfg),
  .rstLocalDma (rstLocalDma),
  .locAccessEn (locAccessEn),
  .hostRetry   (hostRetry),
  .locRdData   (locRdData)
);

// File: tb/brg_rst_init_test.sv
module brg_rst_init_test;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;

  typedef struct packed {
    logic [1:0]    op;      // 0 none, 1 host write, 2 local write
    logic [AW-1:0] wrAddr;
    logic [DW-1:0] wrData;
    logic          done;
    logic [AW-1:0] rdAddr;
    logic [DW-1:0] expRd;
    logic          expRetry;
    logic          expLocOk;
    logic          expLrstN;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'hEC, 32'hA000_0000, 1'b0, 8'hEC, 32'hA000_0000, 1'b0, 1'b1, 1'b1}, // R9 R7 set
    '{2'd0, 8'h00, 32'h0,         1'b1, 8'hEC, 32'h8000_0000, 1'b0, 1'b1, 1'b1}, // R7 done clears
    '{2'd1, 8'hEC, 32'h4000_0000, 1'b0, 8'hEC, 32'hC000_0000, 1'b0, 1'b0, 1'b0}, // R5 sw reset on
    '{2'd2, 8'hEC, 32'h2000_0000, 1'b0, 8'hEC, 32'hC000_0000, 1'b0, 1'b0, 1'b0}, // R6 local ignored
    '{2'd1, 8'hEC, 32'h6000_0000, 1'b0, 8'hEC, 32'hE000_0000, 1'b0, 1'b0, 1'b0}, // R7 host sets reload
    '{2'd1, 8'hEC, 32'h0,         1'b1, 8'hEC, 32'h8000_0000, 1'b0, 1'b1, 1'b1}, // R5 host clears, R9 done kept
    '{2'd2, 8'hEC, 32'h0,         1'b0, 8'hEC, 32'h8000_0000, 1'b0, 1'b1, 1'b1}, // R9 write 0 no clear
    '{2'd1, 8'h04, 32'hFFFF_FFFF, 1'b0, 8'h04, 32'h0000_0007, 1'b0, 1'b1, 1'b1}, // R11 R10
    '{2'd0, 8'h00, 32'h0,         1'b0, 8'h10, 32'h0,         1'b0, 1'b1, 1'b1}, // R10 other offset
    '{2'd2, 8'hEC, 32'hA000_0000, 1'b1, 8'hEC, 32'hA000_0000, 1'b0, 1'b1, 1'b1}, // R7 write wins
    '{2'd0, 8'h00, 32'h0,         1'b1, 8'hEC, 32'h8000_0000, 1'b0, 1'b1, 1'b1}  // R7 done clears
  };

  logic clk = 1'b0;
  logic hostRstN, localRstInN, waitStrap;
  logic hostWrEn, locWrEn, eeLoadDone;
  logic [AW-1:0] hostAddr, locAddr;
  logic [DW-1:0] hostWrData, locWrData, hostRdData, locRdData;
  logic eeReloadReq, localRstOutN, rstHostCfg, rstRuntime, rstLocalCfg, rstLocalDma;
  logic locAccessEn, hostRetry;
  logic [2:0] cmdEnables;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  brg_rst_init uut (
    .clk(clk), .hostRstN(hostRstN), .localRstInN(localRstInN), .waitStrap(waitStrap),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .locWrEn(locWrEn), .locAddr(locAddr), .locWrData(locWrData), .locRdData(locRdData),
    .eeLoadDone(eeLoadDone), .eeReloadReq(eeReloadReq), .localRstOutN(localRstOutN),
    .rstHostCfg(rstHostCfg), .rstRuntime(rstRuntime), .rstLocalCfg(rstLocalCfg),
    .rstLocalDma(rstLocalDma), .locAccessEn(locAccessEn), .hostRetry(hostRetry),
    .cmdEnables(cmdEnables)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    hostWrEn   = (v.op == 2'd1);
    locWrEn    = (v.op == 2'd2);
    hostAddr   = v.wrAddr;
    locAddr    = v.wrAddr;
    hostWrData = v.wrData;
    locWrData  = v.wrData;
    eeLoadDone = v.done;
    @(posedge clk);
    #1;
    hostWrEn = 1'b0; locWrEn = 1'b0; eeLoadDone = 1'b0;
    hostAddr = v.rdAddr; locAddr = 8'hEC;
    #1;
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    vec_t v;
    v = '0; v.op = 2'd1; v.wrAddr = a; v.wrData = d; v.rdAddr = a;
    step(v);
  endtask

  initial begin
    #(PERIOD*5000);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    hostRstN = 1'b0; localRstInN = 1'b1; waitStrap = 1'b1;
    hostWrEn = 1'b0; locWrEn = 1'b0; eeLoadDone = 1'b0;
    hostAddr = 8'hEC; locAddr = 8'hEC; hostWrData = '0; locWrData = '0;
    #1;
    // R2 reset state
    chk("R2 rstHostCfg", 32'(rstHostCfg), 32'd1);
    chk("R2 rstRuntime", 32'(rstRuntime), 32'd1);
    chk("R2 rstLocalDma", 32'(rstLocalDma), 32'd1);
    chk("R2 ic read", hostRdData, 32'h0);
    chk("R1 lrst under host reset", 32'(localRstOutN), 32'd0);
    repeat (3) @(posedge clk);
    // R3 release timing
    @(negedge clk); hostRstN = 1'b1;
    @(posedge clk); #1;
    chk("R3 still held after first edge", 32'(localRstOutN), 32'd0);
    @(posedge clk); #1;
    chk("R3 released on second edge", 32'(localRstOutN), 32'd1);
    chk("R3 host group released", 32'(rstHostCfg), 32'd0);
    chk("R8 retry before init", 32'(hostRetry), 32'd1);
    // R8 host write ignored while retrying
    hostWrite(8'h04, 32'h7);
    chk("R8 cmd write ignored under retry", hostRdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i]);
      chk($sformatf("R10 vector %0d read", i), hostRdData, VECS[i].expRd);
      chk($sformatf("R8 vector %0d retry", i), 32'(hostRetry), 32'(VECS[i].expRetry));
      chk($sformatf("R6 vector %0d locAccessEn", i), 32'(locAccessEn), 32'(VECS[i].expLocOk));
      chk($sformatf("R1 vector %0d localRstOutN", i), 32'(localRstOutN), 32'(VECS[i].expLrstN));
    end

    // R5 software reset groups
    hostWrite(8'hEC, 32'h4000_0000);
    chk("R5 local cfg reset", 32'(rstLocalCfg), 32'd1);
    chk("R5 host cfg kept", 32'(rstHostCfg), 32'd0);
    chk("R5 runtime kept", 32'(rstRuntime), 32'd0);
    chk("R6 local read muted", locRdData, 32'h0);
    hostAddr = 8'h04; #1;
    chk("R5 cmd retained", hostRdData, 32'h7);
    hostWrite(8'hEC, 32'h0);
    chk("R6 local read back", locRdData, 32'h8000_0000);
    chk("R11 cmd port", 32'(cmdEnables), 32'h7);

    // R4 local reset input
    hostWrite(8'hEC, 32'h2000_0000);   // reload bit on, to see it kept
    @(negedge clk); localRstInN = 1'b0; #1;
    chk("R1 lrst follows local input", 32'(localRstOutN), 32'd0);
    chk("R4 local dma reset", 32'(rstLocalDma), 32'd1);
    chk("R4 host cfg untouched", 32'(rstHostCfg), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); localRstInN = 1'b1;
    repeat (3) @(posedge clk);
    #1; hostAddr = 8'hEC; #1;
    chk("R4 init done cleared, reload kept", hostRdData, 32'h2000_0000);
    chk("R9 retry back on", 32'(hostRetry), 32'd1);
    hostAddr = 8'h04; #1;
    chk("R4 cmd kept", hostRdData, 32'h7);

    // R8 strap low lifts retry
    @(negedge clk); waitStrap = 1'b0; #1;
    chk("R8 strap low no retry", 32'(hostRetry), 32'd0);
    hostWrite(8'h04, 32'h2);
    chk("R11 host write with strap low", hostRdData, 32'h2);
    hostWrite(8'hEC, 32'h8000_0000);
    chk("R9 host cannot set init done", hostRdData, 32'h2000_0000);

    // R2 host reset mid operation
    @(negedge clk); hostRstN = 1'b0; #1;
    chk("R2 cmd cleared", 32'(cmdEnables), 32'h0);
    chk("R2 ic cleared", hostRdData, 32'h0);
    chk("R2 reload request dropped", 32'(eeReloadReq), 32'd0);
    chk("R2 local cfg reset", 32'(rstLocalCfg), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule